// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block is a synchronous supervisor for a processor subsystem. It runs on the system clock and counts time in timebase ticks, which arrive as a one-cycle enable on `tick`. A low-supply status bit, the processor's watchdog strobe and a chip-enable request are its other inputs. It produces an active-low reset with a matching active-high copy, a watchdog fault flag and a gated chip-enable. All analog sensing is outside the block: low-supply arrives already decided, as a synchronous digital bit.

The watchdog strobe has two inputs. One carries its logic level. A separate enable stands for a three-level pin: with the enable low, the line counts as floating and the watchdog is off. Either edge of the level restarts the timeout. If the strobe stays static for longer than the selected timeout, the fault flag drops and a reset pulse of fixed length is issued. The pulses repeat every timeout period until software services the strobe again. While low-supply is active, reset is held asserted. After low-supply clears, reset stays asserted for the full delay, so a supply that keeps dropping out cannot make reset chatter.

Top module: `wdog_supervisor`

## Requirements
- R1: While `init_rst` is high, and in the first cycle after it falls, `rst_n_o`=0, `rst_o`=1, `wd_fault_n`=1 and `ce_out_n`=1.
- R2: Once `low_line` is clear (or after the initial reset), reset stays asserted for RST_DLY further ticks and then deasserts. With `tick` high every cycle, that is RST_DLY clock cycles, give or take one.
- R3: `rst_o` is always the logical inverse of `rst_n_o`.
- R4: While `wd_enable` is low, no watchdog timeout occurs and `wd_fault_n` is 1, including when it was 0 before the enable fell.
- R5: When the strobe level stays static for the selected timeout, `wd_fault_n` goes to 0 and a reset pulse of RST_DLY ticks is issued. The pulse starts 1 to 5 cycles after the timeout expires (two-flop synchronizer, edge register, timeout register).
- R6: While the strobe stays unserviced, a new reset pulse follows each completed timeout. The count is cleared during reset, so the gap between pulses is one timeout, and `wd_fault_n` stays 0 throughout.
- R7: A strobe edge that arrives while reset is asserted leaves `wd_fault_n` at 0. A strobe edge while reset is deasserted returns it to 1.
- R8: A rising edge or a falling edge of the strobe restarts the timeout, so toggling the strobe more often than the timeout prevents any reset.
- R9: `long_sel`=1 selects a timeout of LONG_TO ticks (default 4096) and `long_sel`=0 a timeout of SHORT_TO ticks (default 1024).
- R10: While `low_line` is 1, reset is asserted from the next cycle on and stays asserted.
- R11: While `low_line` is 1, `wd_fault_n` is 1 from the next cycle on.
- R12: `ce_out_n` is registered. One cycle after the inputs, it is 0 only if `ce_in_n`=0 and `low_line`=0; otherwise it is 1.
- R13: All delays count only cycles with `tick`=1. With a tick every third cycle, the reset delay lasts about three times as many clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| init_rst | input | 1 | Synchronous initial reset, active high |
| tick | input | 1 | Timebase enable, one cycle per tick |
| low_line | input | 1 | Low-supply status, 1 = supply low |
| wd_level | input | 1 | Watchdog strobe level (asynchronous) |
| wd_enable | input | 1 | Watchdog strobe driven; 0 = floating, watchdog off |
| long_sel | input | 1 | 1 = long timeout, 0 = short timeout |
| ce_in_n | input | 1 | Chip-enable request, active low |
| rst_n_o | output | 1 | Reset, active low |
| rst_o | output | 1 | Reset, active high |
| wd_fault_n | output | 1 | Watchdog fault flag, active low |
| ce_out_n | output | 1 | Gated chip-enable, active low |

## Verification
The bench uses short timeouts and a short delay, so it can measure every interval: the initial and post-low-supply reset length, the first timeout under each selection, and the pulse width and gap of the repeating reset. A design that ignored the select, or counted clocks instead of ticks, shows up as an interval outside its window. The bench toggles the strobe in both directions during reset and after it. A flag that cleared during reset, or a timer that restarted on only one edge, shows up as a wrong flag value or as a spurious reset. It also drops the enable and raises low-supply while the flag is low, and it sweeps all four chip-enable combinations. Those checks catch a flag that is not forced high and a gate that ignores low-supply.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;
   typedef enum logic [1:0] {
      RG_RUN   = 2'd0,
      RG_HOLD  = 2'd1,
      RG_DELAY = 2'd2
   } rg_state_e;

   function automatic int cnt_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/wdsup_sync.sv
module wdsup_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic init_rst,
   input  logic lvl_async,
   input  logic en_async,
   output logic en_s,
   output logic strobe_edge
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wdsup_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] lvl_q;
   logic [STAGES-1:0] en_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (init_rst) begin
         lvl_q  <= '0;
         en_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         lvl_q  <= {lvl_q[STAGES-2:0], lvl_async};
         en_q   <= {en_q[STAGES-2:0], en_async};
         prev_q <= lvl_q[STAGES-1];
      end
   end

   assign en_s        = en_q[STAGES-1];
   assign strobe_edge = en_q[STAGES-1] & (lvl_q[STAGES-1] ^ prev_q);
endmodule

// File: rtl/wdsup_timer.sv
module wdsup_timer
   import wdsup_pkg::*;
#(
   parameter int LONG_TO  = 4096,
   parameter int SHORT_TO = 1024
) (
   input  logic clk,
   input  logic init_rst,
   input  logic tick,
   input  logic en_s,
   input  logic strobe_edge,
   input  logic long_sel,
   input  logic rst_act,
   input  logic low_line,
   output logic fire,
   output logic fault_n
);
   localparam int CW = cnt_bits(LONG_TO);

   generate
      if (SHORT_TO < 2 || LONG_TO < SHORT_TO) begin : g_bad_to
         $error("wdsup_timer: need 2 <= SHORT_TO <= LONG_TO");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim_m1;

   assign lim_m1 = long_sel ? CW'(LONG_TO - 1) : CW'(SHORT_TO - 1);

   always_ff @(posedge clk) begin
      if (init_rst || !en_s || rst_act) begin
         cnt_q <= '0;
         fire  <= 1'b0;
      end else begin
         fire <= 1'b0;
         if (strobe_edge) begin
            cnt_q <= '0;
         end else if (tick) begin
            if (cnt_q >= lim_m1) begin
               cnt_q <= '0;
               fire  <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (init_rst)                  fault_n <= 1'b1;
      else if (low_line || !en_s)    fault_n <= 1'b1;
      else if (fire)                 fault_n <= 1'b0;
      else if (strobe_edge && !rst_act) fault_n <= 1'b1;
   end

   p_disabled_r4: assert property (@(posedge clk) disable iff (init_rst)
      !en_s |=> !fire);
   p_lowline_fault_r11: assert property (@(posedge clk) disable iff (init_rst)
      low_line |=> fault_n);
   p_fault_fall_r5: assert property (@(posedge clk) disable iff (init_rst)
      $fell(fault_n) |-> $past(fire));
   p_hold_clear_r7: assert property (@(posedge clk) disable iff (init_rst)
      (!fault_n && rst_act && !low_line && en_s) |=> !fault_n);
endmodule

// File: rtl/wdsup_rstgen.sv
module wdsup_rstgen
   import wdsup_pkg::*;
#(
   parameter int RST_DLY = 128
) (
   input  logic clk,
   input  logic init_rst,
   input  logic tick,
   input  logic low_line,
   input  logic wd_fire,
   output logic rst_q,
   output logic rst_n_q
);
   localparam int DW = cnt_bits(RST_DLY);

   generate
      if (RST_DLY < 2) begin : g_bad_dly
         $error("wdsup_rstgen: RST_DLY must be at least 2");
      end
   endgenerate

   rg_state_e     st_q, st_d;
   logic [DW-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      if (low_line) begin
         st_d  = RG_HOLD;
         cnt_d = '0;
      end else if (wd_fire) begin
         st_d  = RG_DELAY;
         cnt_d = '0;
      end else if (st_q != RG_RUN && tick) begin
         if (cnt_q == DW'(RST_DLY - 1)) begin
            st_d  = RG_RUN;
            cnt_d = '0;
         end else begin
            st_d  = RG_DELAY;
            cnt_d = cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (init_rst) begin
         st_q    <= RG_DELAY;
         cnt_q   <= '0;
         rst_q   <= 1'b1;
         rst_n_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         cnt_q   <= cnt_d;
         rst_q   <= (st_d != RG_RUN);
         rst_n_q <= (st_d == RG_RUN);
      end
   end

   p_lowline_rst_r10: assert property (@(posedge clk) disable iff (init_rst)
      low_line |=> (rst_q && st_q == RG_HOLD));
   p_fire_rst_r5: assert property (@(posedge clk) disable iff (init_rst)
      wd_fire |=> rst_q);
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
   parameter int RST_DLY     = 128,
   parameter int LONG_TO     = 4096,
   parameter int SHORT_TO    = 1024,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic init_rst,
   input  logic tick,
   input  logic low_line,
   input  logic wd_level,
   input  logic wd_enable,
   input  logic long_sel,
   input  logic ce_in_n,
   output logic rst_n_o,
   output logic rst_o,
   output logic wd_fault_n,
   output logic ce_out_n
);
   logic en_s, strobe_edge, fire;

   wdsup_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .init_rst(init_rst), .lvl_async(wd_level), .en_async(wd_enable),
      .en_s(en_s), .strobe_edge(strobe_edge)
   );

   wdsup_timer #(.LONG_TO(LONG_TO), .SHORT_TO(SHORT_TO)) u_timer (
      .clk(clk), .init_rst(init_rst), .tick(tick), .en_s(en_s),
      .strobe_edge(strobe_edge), .long_sel(long_sel), .rst_act(rst_o),
      .low_line(low_line), .fire(fire), .fault_n(wd_fault_n)
   );

   wdsup_rstgen #(.RST_DLY(RST_DLY)) u_rstgen (
      .clk(clk), .init_rst(init_rst), .tick(tick), .low_line(low_line),
      .wd_fire(fire), .rst_q(rst_o), .rst_n_q(rst_n_o)
   );

   always_ff @(posedge clk) begin
      if (init_rst) ce_out_n <= 1'b1;
      else          ce_out_n <= ce_in_n | low_line;
   end

   p_inverse_r3: assert property (@(posedge clk) disable iff (init_rst)
      rst_o == !rst_n_o);
   p_ce_gate_r12: assert property (@(posedge clk) disable iff (init_rst)
      (!ce_in_n && !low_line) |=> !ce_out_n);
   p_ce_block_r12: assert property (@(posedge clk) disable iff (init_rst)
      (ce_in_n || low_line) |=> ce_out_n);
endmodule

// File: tb/tb_wdog_supervisor.sv
module tb_wdog_supervisor;
   localparam int RD = 8;
   localparam int LT = 48;
   localparam int ST = 16;

   logic clk = 0, init_rst = 1, tick = 1, low_line = 0, wd_level = 0;
   logic wd_enable = 0, long_sel = 0, ce_in_n = 1;
   logic rst_n_o, rst_o, wd_fault_n, ce_out_n;
   int total = 0, bad = 0, tick_div = 1, tcnt = 0;
   bit done = 0;

   wdog_supervisor #(.RST_DLY(RD), .LONG_TO(LT), .SHORT_TO(ST)) dut (
      .clk(clk), .init_rst(init_rst), .tick(tick), .low_line(low_line),
      .wd_level(wd_level), .wd_enable(wd_enable), .long_sel(long_sel),
      .ce_in_n(ce_in_n), .rst_n_o(rst_n_o), .rst_o(rst_o),
      .wd_fault_n(wd_fault_n), .ce_out_n(ce_out_n)
   );

   always #4 clk = ~clk;

   always @(negedge clk) begin
      if (tcnt + 1 >= tick_div) begin tcnt = 0; tick = 1; end
      else begin tcnt = tcnt + 1; tick = 0; end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input int act, input int lo, input int hi);
      total++;
      if (act < lo || act > hi) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic until_low(output int n, input int lim);
      n = 0;
      while (rst_n_o !== 1'b0 && n < lim) begin @(negedge clk); n++; end
   endtask

   task automatic until_high(output int n, input int lim, output bit inv_bad);
      n = 0; inv_bad = 0;
      while (rst_n_o !== 1'b1 && n < lim) begin
         if (rst_o !== ~rst_n_o) inv_bad = 1;
         @(negedge clk); n++;
      end
   endtask

   task automatic finish_up;
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_up();
   end

   initial begin
      int n, flt;
      bit ib;
      // R1: reset state
      cyc(3);
      chk(rst_n_o == 0 && rst_o == 1 && wd_fault_n == 1 && ce_out_n == 1,
          "R1 init outputs", {rst_n_o, rst_o, wd_fault_n, ce_out_n}, 4'b0111);
      init_rst = 0;
      @(negedge clk);
      chk(rst_n_o == 0 && wd_fault_n == 1, "R1 first cycle after init", rst_n_o, 0);
      // R2 and R3: delay after initial reset
      until_high(n, 1000, ib);
      chk_rng("R2 delay after init", n + 1, RD - 1, RD + 1);
      chk(!ib, "R3 inverse during reset", ib, 0);
      // R4: disabled watchdog, static strobe, no timeout
      flt = 0;
      for (int i = 0; i < 2 * LT; i++) begin
         @(negedge clk);
         if (rst_n_o !== 1 || wd_fault_n !== 1) flt++;
      end
      chk(flt == 0, "R4 disabled no timeout", flt, 0);
      // R5: short timeout from enable
      wd_enable = 1;
      until_low(n, 1000);
      chk_rng("R5 short timeout latency", n, ST + 1, ST + 5);
      chk(wd_fault_n == 0, "R5 fault low at timeout", wd_fault_n, 0);
      // R6: repeated pulses, width and gap
      until_high(n, 1000, ib);
      chk_rng("R5 pulse width", n, RD - 1, RD + 1);
      chk(!ib, "R3 inverse during pulse", ib, 0);
      until_low(n, 1000);
      chk_rng("R6 gap between pulses", n, ST - 1, ST + 2);
      chk(wd_fault_n == 0, "R6 fault stays low", wd_fault_n, 0);
      // R7: edge during reset leaves fault low
      @(negedge clk);
      wd_level = ~wd_level;
      cyc(4);
      chk(rst_n_o == 0, "R7 still in reset", rst_n_o, 0);
      chk(wd_fault_n == 0, "R7 edge in reset ignored", wd_fault_n, 0);
      until_high(n, 1000, ib);
      @(negedge clk);
      wd_level = ~wd_level;
      cyc(4);
      chk(wd_fault_n == 1, "R7 edge after reset clears", wd_fault_n, 1);
      // R8: service with both edge directions
      flt = 0;
      for (int k = 0; k < 24; k++) begin
         for (int i = 0; i < ST - 6; i++) begin
            @(negedge clk);
            if (rst_n_o !== 1 || wd_fault_n !== 1) flt++;
         end
         wd_level = ~wd_level;
      end
      chk(flt == 0, "R8 serviced no reset", flt, 0);
      // R9: long timeout
      long_sel = 1;
      until_low(n, 1000);
      chk_rng("R9 long timeout latency", n, LT + 1, LT + 5);
      // R4: disabling forces fault high
      wd_enable = 0;
      cyc(RD + 6);
      chk(wd_fault_n == 1, "R4 fault high when disabled", wd_fault_n, 1);
      flt = 0;
      for (int i = 0; i < 2 * LT; i++) begin
         @(negedge clk);
         if (rst_n_o !== 1) flt++;
      end
      chk(flt == 0, "R4 no reset when disabled", flt, 0);
      // R10, R11: low line with fault low
      wd_enable = 1;
      until_low(n, 1000);
      chk(wd_fault_n == 0, "R11 fault low before low line", wd_fault_n, 0);
      low_line = 1;
      cyc(2);
      chk(wd_fault_n == 1, "R11 fault forced high", wd_fault_n, 1);
      flt = 0;
      for (int i = 0; i < 2 * LT; i++) begin
         @(negedge clk);
         if (rst_n_o !== 0) flt++;
      end
      chk(flt == 0, "R10 reset held in low line", flt, 0);
      low_line = 0;
      until_high(n, 1000, ib);
      chk_rng("R2 delay after low line", n, RD - 1, RD + 1);
      // R13: slower tick
      wd_enable = 0;
      cyc(6);
      tick_div = 3;
      low_line = 1;
      cyc(5);
      low_line = 0;
      until_high(n, 1000, ib);
      chk_rng("R13 delay in ticks", n, 3 * RD - 3, 3 * RD + 3);
      tick_div = 1;
      // R12: chip-enable gating sweep
      for (int v = 0; v < 4; v++) begin
         ce_in_n = v[0];
         low_line = v[1];
         @(negedge clk);
         chk(ce_out_n == (v[0] | v[1]), "R12 ce gating", ce_out_n, v[0] | v[1]);
      end
      low_line = 0;
      cyc(2);
      finish_up();
   end
endmodule